// File: doc/BRIEF.md
# Segmented Address Translator

The block maps a 14-bit virtual address onto a 16-bit physical address through a four-entry segment table kept in flip-flops. The two most significant address bits pick a table entry. The remaining twelve bits are an offset. The offset is compared against the segment's length and then added to the segment's start. Each entry also carries a valid flag, a read-enable flag and a write-enable flag. A lookup that breaks one of these rules returns a fault with a cause code and no address. Software uses these faults to allocate a segment on first touch or to copy a shared segment on its first write.

The lookup itself is combinational. Its result is captured in an output register, so a response appears one cycle after its request. A configuration write port replaces one table entry per cycle. Out of reset the table already holds a usable layout:

| Segment | Start | Length | Access |
|---|---|---|---|
| 0 | 0x4000 | 0x700 | read-only |
| 1 | 0x0000 | 0x500 | read/write |
| 2 | — | — | invalid |
| 3 | 0x2000 | 0x1000 | read/write |

Top module: `seg_xlate`

## Requirements
- R1: After reset the table holds the following four segments. Segment 0 starts at 0x4000, has length 0x700, is valid and allows reads only. Segment 1 starts at 0x0000, has length 0x500 and allows reads and writes. Segment 2 is invalid. Segment 3 starts at 0x2000, has length 0x1000 and allows reads and writes.
- R2: The virtual address is split into a segment number in bits [13:12] and an offset in bits [11:0]. A request accepted at one rising edge produces rsp_valid_o high in the following cycle. When the request is permitted, rsp_paddr_o equals the segment start plus the offset, modulo 2^16.
- R3: An offset greater than or equal to the segment length gives rsp_fault_o=1 with rsp_cause_o=2'b10. In that case rsp_paddr_o is 0.
- R4: Any reference to a segment whose valid flag is clear gives rsp_fault_o=1 with rsp_cause_o=2'b01, whatever its offset or access type. In that case rsp_paddr_o is 0.
- R5: A write (req_write_i=1) to a segment without write permission faults with rsp_cause_o=2'b11. A read (req_write_i=0) of a segment without read permission also faults with rsp_cause_o=2'b11. In both cases rsp_paddr_o is 0.
- R6: When several faults apply, the reported cause follows a fixed priority. An invalid segment (2'b01) is reported first, then a length violation (2'b10), then a permission violation (2'b11).
- R7: A configuration write loads entry cfg_idx_i from cfg_start_i, cfg_len_i, cfg_valid_i, cfg_read_i and cfg_write_i. The new entry is used from the next cycle. A translation requested in the same cycle as the write uses the old entry.
- R8: In a cycle after no request, rsp_valid_o, rsp_fault_o, rsp_cause_o and rsp_paddr_o are all 0.
- R9: A permitted translation reports rsp_fault_o=0 and rsp_cause_o=2'b00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Translation request strobe |
| req_addr_i | input | 14 | Virtual address |
| req_write_i | input | 1 | 1 = write access, 0 = read access |
| cfg_we_i | input | 1 | Table entry write strobe |
| cfg_idx_i | input | 2 | Entry to write |
| cfg_start_i | input | 16 | New segment start |
| cfg_len_i | input | 13 | New segment length |
| cfg_valid_i | input | 1 | New valid flag |
| cfg_read_i | input | 1 | New read-enable flag |
| cfg_write_i | input | 1 | New write-enable flag |
| rsp_valid_o | output | 1 | Response valid, one cycle after the request |
| rsp_paddr_o | output | 16 | Physical address, 0 on a fault |
| rsp_fault_o | output | 1 | Translation faulted |
| rsp_cause_o | output | 2 | 00 none, 01 invalid, 10 length, 11 permission |

## Verification
A table write and a translation of the same entry can fall in the same cycle. The bench provokes this by writing a new start, length and valid flag into the invalid segment 2 while requesting an address in segment 2 on that same edge. The response to that request must still show the invalid-segment fault from the old entry. A second request on the following cycle must return the new start plus the offset. Priority among overlapping faults is judged by rewriting a segment so that one address breaks both its length and its permission rules, and checking that only the length cause is reported.

// File: rtl/seg_xlate_pkg.sv
package seg_xlate_pkg;
  localparam int unsigned SEG_W = 2;
  localparam int unsigned OFF_W = 12;
  localparam int unsigned VA_W  = SEG_W + OFF_W;
  localparam int unsigned PA_W  = 16;
  localparam int unsigned LEN_W = OFF_W + 1;
  localparam int unsigned N_SEG = 1 << SEG_W;

  typedef enum logic [1:0] {
    CAUSE_NONE    = 2'b00,
    CAUSE_INVALID = 2'b01,
    CAUSE_LENGTH  = 2'b10,
    CAUSE_PERM    = 2'b11
  } cause_e;

  typedef struct packed {
    logic [PA_W-1:0]  start;
    logic [LEN_W-1:0] len;
    logic             vld;
    logic             rd;
    logic             wr;
  } seg_entry_t;

  function automatic seg_entry_t reset_entry(input int unsigned idx);
    seg_entry_t e;
    e = '0;
    case (idx)
      0: begin e.start = 16'h4000; e.len = 13'h0700; e.vld = 1'b1; e.rd = 1'b1; e.wr = 1'b0; end
      1: begin e.start = 16'h0000; e.len = 13'h0500; e.vld = 1'b1; e.rd = 1'b1; e.wr = 1'b1; end
      3: begin e.start = 16'h2000; e.len = 13'h1000; e.vld = 1'b1; e.rd = 1'b1; e.wr = 1'b1; end
      default: e = '0;
    endcase
    return e;
  endfunction
endpackage

// File: rtl/seg_table.sv
module seg_table
  import seg_xlate_pkg::*;
(
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    we_i,
  input  logic [SEG_W-1:0]        idx_i,
  input  seg_entry_t              wdata_i,
  output seg_entry_t [N_SEG-1:0]  tbl_o
);
  for (genvar g = 0; g < N_SEG; g++) begin : g_ent
    seg_entry_t ent_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                              ent_q <= reset_entry(g);
      else if (we_i && (idx_i == SEG_W'(g)))    ent_q <= wdata_i;
    end
    assign tbl_o[g] = ent_q;
  end

  // R7: written entry visible on the next cycle
  assert_write_next_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we_i |=> tbl_o[$past(idx_i)] == $past(wdata_i));
endmodule

// File: rtl/seg_check.sv
module seg_check
  import seg_xlate_pkg::*;
(
  input  seg_entry_t        ent_i,
  input  logic [OFF_W-1:0]  off_i,
  input  logic              write_i,
  output logic [PA_W-1:0]   paddr_o,
  output cause_e            cause_o
);
  logic len_bad, perm_bad;

  always_comb begin
    len_bad  = {1'b0, off_i} >= ent_i.len;
    perm_bad = write_i ? !ent_i.wr : !ent_i.rd;
    // priority: invalid, length, permission
    if (!ent_i.vld)    cause_o = CAUSE_INVALID;
    else if (len_bad)  cause_o = CAUSE_LENGTH;
    else if (perm_bad) cause_o = CAUSE_PERM;
    else               cause_o = CAUSE_NONE;
    paddr_o = (cause_o == CAUSE_NONE) ? ent_i.start + PA_W'(off_i) : '0;
  end
endmodule

// File: rtl/seg_out_stage.sv
module seg_out_stage
  import seg_xlate_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             req_i,
  input  logic [PA_W-1:0]  paddr_i,
  input  cause_e           cause_i,
  output logic             valid_o,
  output logic [PA_W-1:0]  paddr_o,
  output logic             fault_o,
  output logic [1:0]       cause_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o <= 1'b0;
      paddr_o <= '0;
      fault_o <= 1'b0;
      cause_o <= CAUSE_NONE;
    end else begin
      valid_o <= req_i;
      paddr_o <= req_i ? paddr_i : '0;
      fault_o <= req_i && (cause_i != CAUSE_NONE);
      cause_o <= req_i ? cause_i : CAUSE_NONE;
    end
  end

  assert_valid_latency_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_i |=> valid_o);
  assert_fault_no_addr_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fault_o |-> (paddr_o == '0) && valid_o);
  assert_idle_quiet_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !req_i |=> !valid_o && !fault_o && (cause_o == 2'b00) && (paddr_o == '0));
  assert_cause_match_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> (fault_o == (cause_o != 2'b00)));
endmodule

// File: rtl/seg_xlate.sv
module seg_xlate
  import seg_xlate_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  input  logic [13:0]       req_addr_i,
  input  logic              req_write_i,
  input  logic              cfg_we_i,
  input  logic [1:0]        cfg_idx_i,
  input  logic [15:0]       cfg_start_i,
  input  logic [12:0]       cfg_len_i,
  input  logic              cfg_valid_i,
  input  logic              cfg_read_i,
  input  logic              cfg_write_i,
  output logic              rsp_valid_o,
  output logic [15:0]       rsp_paddr_o,
  output logic              rsp_fault_o,
  output logic [1:0]        rsp_cause_o
);
  seg_entry_t [N_SEG-1:0] tbl;
  seg_entry_t             wdata, sel;
  logic [SEG_W-1:0]       seg;
  logic [OFF_W-1:0]       off;
  logic [PA_W-1:0]        paddr;
  cause_e                 cause;

  assign wdata = '{start: cfg_start_i, len: cfg_len_i, vld: cfg_valid_i,
                   rd: cfg_read_i, wr: cfg_write_i};
  assign seg   = req_addr_i[VA_W-1 -: SEG_W];
  assign off   = req_addr_i[OFF_W-1:0];
  assign sel   = tbl[seg];

  seg_table u_table (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (cfg_we_i),
    .idx_i   (cfg_idx_i),
    .wdata_i (wdata),
    .tbl_o   (tbl)
  );

  seg_check u_check (
    .ent_i   (sel),
    .off_i   (off),
    .write_i (req_write_i),
    .paddr_o (paddr),
    .cause_o (cause)
  );

  seg_out_stage u_out (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .req_i   (req_valid_i),
    .paddr_i (paddr),
    .cause_i (cause),
    .valid_o (rsp_valid_o),
    .paddr_o (rsp_paddr_o),
    .fault_o (rsp_fault_o),
    .cause_o (rsp_cause_o)
  );

  // R4 and R6: an invalid entry always yields the invalid cause
  assert_invalid_first_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && !sel.vld) |=> rsp_fault_o && (rsp_cause_o == 2'b01));
endmodule

// File: tb/seg_xlate_test.sv
module seg_xlate_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0, req_write = 1'b0;
  logic [13:0] req_addr = '0;
  logic        cfg_we = 1'b0, cfg_valid = 1'b0, cfg_read = 1'b0, cfg_write = 1'b0;
  logic [1:0]  cfg_idx = '0;
  logic [15:0] cfg_start = '0;
  logic [12:0] cfg_len = '0;
  logic        rsp_valid, rsp_fault;
  logic [15:0] rsp_paddr;
  logic [1:0]  rsp_cause;
  int          n_run = 0, n_fail = 0;
  bit          done = 1'b0;

  always #2.5 clk = ~clk;

  seg_xlate uut (
    .clk_i(clk), .rst_ni(rst_n),
    .req_valid_i(req_valid), .req_addr_i(req_addr), .req_write_i(req_write),
    .cfg_we_i(cfg_we), .cfg_idx_i(cfg_idx), .cfg_start_i(cfg_start), .cfg_len_i(cfg_len),
    .cfg_valid_i(cfg_valid), .cfg_read_i(cfg_read), .cfg_write_i(cfg_write),
    .rsp_valid_o(rsp_valid), .rsp_paddr_o(rsp_paddr),
    .rsp_fault_o(rsp_fault), .rsp_cause_o(rsp_cause)
  );

  task automatic check_rsp(input string req, input logic ev, input logic [15:0] ep,
                           input logic ef, input logic [1:0] ec);
    n_run++;
    if (rsp_valid !== ev || rsp_paddr !== ep || rsp_fault !== ef || rsp_cause !== ec) begin
      n_fail++;
      $display("FAIL %s: got v=%0b pa=%h f=%0b c=%0d, exp v=%0b pa=%h f=%0b c=%0d",
               req, rsp_valid, rsp_paddr, rsp_fault, rsp_cause, ev, ep, ef, ec);
    end
  endtask

  // drive at negedge, registered result sampled at the next negedge
  task automatic xlate(input string req, input logic [13:0] a, input logic w,
                       input logic [15:0] ep, input logic [1:0] ec);
    @(negedge clk);
    req_valid = 1'b1; req_addr = a; req_write = w;
    @(negedge clk);
    req_valid = 1'b0;
    check_rsp(req, 1'b1, ep, ec != 2'b00, ec);
  endtask

  task automatic cfg(input logic [1:0] i, input logic [15:0] s, input logic [12:0] l,
                     input logic v, input logic r, input logic w);
    @(negedge clk);
    cfg_we = 1'b1; cfg_idx = i; cfg_start = s; cfg_len = l;
    cfg_valid = v; cfg_read = r; cfg_write = w;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic t_reset;
    @(negedge clk);
    check_rsp("R8 reset", 1'b0, 16'h0, 1'b0, 2'b00);
  endtask

  task automatic t_defaults;
    xlate("R1 R2 R9 code read", 14'h0100, 1'b0, 16'h4100, 2'b00);
    xlate("R1 R2 code last",    14'h06FF, 1'b0, 16'h46FF, 2'b00);
    xlate("R1 R2 data write",   14'h1004, 1'b1, 16'h0004, 2'b00);
    xlate("R1 R2 stack top",    14'h3FFF, 1'b1, 16'h2FFF, 2'b00);
  endtask

  task automatic t_length;
    xlate("R3 code at length", 14'h0700, 1'b0, 16'h0, 2'b10);
    xlate("R3 data past",      14'h1500, 1'b0, 16'h0, 2'b10);
    xlate("R3 data last ok",   14'h14FF, 1'b0, 16'h04FF, 2'b00);
  endtask

  task automatic t_invalid;
    xlate("R4 heap read",  14'h2000, 1'b0, 16'h0, 2'b01);
    xlate("R4 heap write", 14'h2FFF, 1'b1, 16'h0, 2'b01);
  endtask

  task automatic t_perm;
    xlate("R5 code write", 14'h0010, 1'b1, 16'h0, 2'b11);
    cfg(2'd3, 16'h2000, 13'h1000, 1'b1, 1'b0, 1'b1);
    xlate("R5 stack no read",    14'h3010, 1'b0, 16'h0, 2'b11);
    xlate("R5 stack write ok",   14'h3010, 1'b1, 16'h2010, 2'b00);
  endtask

  task automatic t_priority;
    cfg(2'd1, 16'h0100, 13'h0010, 1'b1, 1'b1, 1'b0);
    xlate("R6 length over perm", 14'h1020, 1'b1, 16'h0, 2'b10);
    xlate("R6 perm in range",    14'h1008, 1'b1, 16'h0, 2'b11);
    cfg(2'd1, 16'h0100, 13'h0010, 1'b0, 1'b0, 1'b0);
    xlate("R6 invalid over all", 14'h1020, 1'b1, 16'h0, 2'b01);
  endtask

  task automatic t_same_cycle;
    @(negedge clk);
    cfg_we = 1'b1; cfg_idx = 2'd2; cfg_start = 16'h8000; cfg_len = 13'h0100;
    cfg_valid = 1'b1; cfg_read = 1'b1; cfg_write = 1'b1;
    req_valid = 1'b1; req_addr = 14'h2010; req_write = 1'b0;
    @(negedge clk);
    cfg_we = 1'b0;
    check_rsp("R7 same cycle old entry", 1'b1, 16'h0, 1'b1, 2'b01);
    @(negedge clk);
    req_valid = 1'b0;
    check_rsp("R7 next cycle new entry", 1'b1, 16'h8010, 1'b0, 2'b00);
    @(negedge clk);
    check_rsp("R8 idle after request", 1'b0, 16'h0, 1'b0, 2'b00);
  endtask

  task automatic t_wrap;
    cfg(2'd0, 16'hFF00, 13'h1000, 1'b1, 1'b1, 1'b1);
    xlate("R2 wrap modulo", 14'h0200, 1'b0, 16'h0100, 2'b00);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_defaults();
    t_length();
    t_invalid();
    t_perm();
    t_priority();
    t_same_cycle();
    t_wrap();
    done = 1'b1;
  end

  initial begin : watchdog
    fork
      wait (done);
      begin
        repeat (5000) @(posedge clk);
        n_run++; n_fail++;
        $display("FAIL watchdog: got timeout, exp completion");
      end
    join_any
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule